// File: doc/BRIEF.md
# Three-Input NAND Network Function Evaluator

This block accepts a description of a small feed-forward network of NAND gates and returns the Boolean function that network computes over three inputs `a`, `b` and `c`. The description is a connection matrix with one row per gate. Each row chooses which signals feed that gate. A row may pick from the six literals (`a`, `b`, `c` and their complements) and from the outputs of gates in earlier rows.

A matrix is presented with a one-cycle `in_valid` strobe. The block then steps through all eight input combinations. For each combination it evaluates the gates one per cycle, in row order. Each gate's result goes into a shared working register, where later gates can read it. When all eight combinations are done, the block pulses `out_valid` for one cycle and presents the 8-bit truth table. A search engine or a catalog builder can put this block in its inner loop to classify candidate networks.

Top module: `nandnet_tt_eval`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `out_table` is 8'h00.
- R2: The working-register columns are numbered from 0: column 0 is `a`, 1 is `b`, 2 is `c`, 3 is not-`a`, 4 is not-`b`, 5 is not-`c`. Bit i of `out_table` is the network output when `a`=i[2], `b`=i[1], `c`=i[0]. A gate outputs 0 exactly when every selected column holds 1, and outputs 1 otherwise. For example, a gate fed by `a` and not-`a` gives 8'hFF.
- R3: Row k of the matrix occupies `in_matrix[k*ROW_W +: ROW_W]`, with ROW_W = 5 + NG. Bit j of a row selects column j. The result of gate k is written to column 6+k before row k+1 is evaluated. A row's selections of column 6+k or higher are ignored.
- R4: A row with no selected column is an unused gate. An unused gate's column reads as 0. The network output is the result of the highest-numbered used row. A matrix with no used row yields 8'h00.
- R5: `out_valid` is a single-cycle pulse. It is asserted exactly 8*NG clock cycles after the edge that accepted `in_valid`.
- R6: `in_valid` is accepted only when no evaluation is in progress. A strobe that arrives while an evaluation is running has no effect on that result or on any later output.
- R7: `out_table` changes only in the cycle in which `out_valid` is asserted, and it holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: sample `in_matrix` when idle |
| in_matrix | input | NG*(5+NG) | Connection matrix, one row per gate |
| out_valid | output | 1 | One-cycle pulse: `out_table` is new |
| out_table | output | 8 | Truth table of the network, bit i = combination i |

## Verification
On every cycle, the assertions check the following:
- the pulse shape and the fixed delay from acceptance to result;
- that the table holds between results;
- that the literal columns are loaded as true/complement pairs at the start of each combination;
- that gates are stepped strictly in row order.

Only the bench's scenarios can show whether the function is correct. Those scenarios cover the NAND rule on literals, chaining through earlier gate columns, masking of forward references, output selection from the highest used row with gaps, the empty matrix, and a strobe arriving mid-run. The bench compares against a behavioural model on every clock.

// File: rtl/nandnet_pkg.sv
package nandnet_pkg;
    localparam int NLIT   = 6;
    localparam int NCOMBO = 8;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_RUN  = 1'b1
    } ev_state_e;
endpackage

// File: rtl/nandnet_literals.sv
module nandnet_literals
    import nandnet_pkg::*;
(
    input  logic [2:0]      combo,
    output logic [NLIT-1:0] lits
);
    // combo[2] is a, combo[1] is b, combo[0] is c
    always_comb begin
        lits[0] = combo[2];
        lits[1] = combo[1];
        lits[2] = combo[0];
        lits[3] = ~combo[2];
        lits[4] = ~combo[1];
        lits[5] = ~combo[0];
    end
endmodule

// File: rtl/nandnet_gate.sv
module nandnet_gate
    import nandnet_pkg::*;
#(
    parameter int NG = 4,
    localparam int ROW_W = NLIT + NG - 1,
    localparam int WK_W  = NLIT + NG,
    localparam int GW    = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic [GW-1:0]    gate_idx,
    input  logic [ROW_W-1:0] row,
    input  logic [WK_W-1:0]  work,
    output logic             y
);
    logic [ROW_W-1:0] hit;

    generate
        for (genvar j = 0; j < ROW_W; j++) begin : g_col
            if (j < NLIT) begin : g_lit
                assign hit[j] = ~row[j] | work[j];
            end else begin : g_fb
                // feedback column j is legal only for gates numbered above j-NLIT
                logic legal;
                assign legal  = (int'(gate_idx) > (j - NLIT));
                assign hit[j] = ~(row[j] & legal) | work[j];
            end
        end
    endgenerate

    assign y = ~(&hit);
endmodule

// File: rtl/nandnet_top_pick.sv
module nandnet_top_pick
    import nandnet_pkg::*;
#(
    parameter int NG = 4,
    localparam int ROW_W = NLIT + NG - 1,
    localparam int MAT_W = NG * ROW_W,
    localparam int GW    = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic [MAT_W-1:0] matrix,
    output logic [GW-1:0]    top_idx,
    output logic             any_used
);
    logic [NG-1:0] used;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_row
            assign used[g] = |matrix[g*ROW_W +: ROW_W];
        end
    endgenerate

    always_comb begin
        top_idx  = '0;
        any_used = 1'b0;
        for (int g = 0; g < NG; g++) begin
            if (used[g]) begin
                top_idx  = GW'(g);
                any_used = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nandnet_tt_eval.sv
module nandnet_tt_eval
    import nandnet_pkg::*;
#(
    parameter int NG = 4,
    localparam int ROW_W = NLIT + NG - 1,
    localparam int MAT_W = NG * ROW_W,
    localparam int WK_W  = NLIT + NG,
    localparam int GW    = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MAT_W-1:0] in_matrix,
    output logic             out_valid,
    output logic [7:0]       out_table
);
    localparam logic [GW-1:0] LAST_GATE = GW'(NG - 1);

    typedef struct packed {
        ev_state_e        state;
        logic [2:0]       combo;
        logic [GW-1:0]    gate;
        logic [MAT_W-1:0] matrix;
        logic [WK_W-1:0]  work;
        logic [7:0]       acc;
        logic [7:0]       table_out;
        logic             valid_out;
    } ev_reg_t;

    ev_reg_t q, d;

    logic [2:0]       lit_combo;
    logic [NLIT-1:0]  lits;
    logic             gate_y;
    logic [GW-1:0]    top_idx;
    logic             any_used;
    logic [WK_W-1:0]  work_upd;
    logic             net_bit;
    logic [7:0]       acc_upd;

    // observation points for the bound checker
    logic             run_w;
    logic [2:0]       combo_w;
    logic [GW-1:0]    gate_w;
    logic [WK_W-1:0]  work_w;

    assign lit_combo = (q.state == EV_IDLE) ? 3'd0 : (q.combo + 3'd1);

    nandnet_literals u_lits (
        .combo (lit_combo),
        .lits  (lits)
    );

    nandnet_gate #(.NG(NG)) u_gate (
        .gate_idx (q.gate),
        .row      (q.matrix[q.gate*ROW_W +: ROW_W]),
        .work     (q.work),
        .y        (gate_y)
    );

    nandnet_top_pick #(.NG(NG)) u_pick (
        .matrix   (q.matrix),
        .top_idx  (top_idx),
        .any_used (any_used)
    );

    always_comb begin
        work_upd = q.work;
        work_upd[NLIT + int'(q.gate)] = gate_y;
        net_bit = any_used ? work_upd[NLIT + int'(top_idx)] : 1'b0;
        acc_upd = q.acc;
        acc_upd[q.combo] = net_bit;
    end

    always_comb begin
        d = q;
        d.valid_out = 1'b0;
        case (q.state)
            EV_IDLE: begin
                if (in_valid) begin
                    d.state  = EV_RUN;
                    d.matrix = in_matrix;
                    d.combo  = 3'd0;
                    d.gate   = '0;
                    d.work   = {{NG{1'b0}}, lits};
                    d.acc    = 8'h00;
                end
            end
            EV_RUN: begin
                d.work = work_upd;
                if (q.gate == LAST_GATE) begin
                    d.acc  = acc_upd;
                    d.gate = '0;
                    if (q.combo == 3'd7) begin
                        d.state     = EV_IDLE;
                        d.table_out = acc_upd;
                        d.valid_out = 1'b1;
                    end else begin
                        d.combo = q.combo + 3'd1;
                        d.work  = {{NG{1'b0}}, lits};
                    end
                end else begin
                    d.gate = q.gate + GW'(1);
                end
            end
            default: d.state = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid_out;
    assign out_table = q.table_out;
    assign run_w     = (q.state == EV_RUN);
    assign combo_w   = q.combo;
    assign gate_w    = q.gate;
    assign work_w    = q.work;
endmodule

// File: rtl/nandnet_tt_eval_chk.sv
module nandnet_tt_eval_chk
    import nandnet_pkg::*;
#(
    parameter int NG = 4,
    localparam int WK_W = NLIT + NG,
    localparam int GW   = (NG > 1) ? $clog2(NG) : 1,
    localparam int LAT  = NCOMBO * NG,
    localparam int CW   = $clog2(LAT + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [7:0]      out_table,
    input logic            run_w,
    input logic [GW-1:0]   gate_w,
    input logic [WK_W-1:0] work_w
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end else if (in_valid && !run_w) begin
            cnt_q <= CW'(LAT);
        end
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                   // R5
    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> !out_valid);                               // R5
    AST_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1)) |=> out_valid);                            // R5
    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_table));                          // R7
    AST_LIT_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && gate_w == '0) |-> (work_w[5:3] == ~work_w[2:0]));  // R2
    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && gate_w != GW'(NG - 1)) |=> (gate_w == $past(gate_w) + GW'(1))); // R3
endmodule

bind nandnet_tt_eval nandnet_tt_eval_chk #(.NG(NG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_table (out_table),
    .run_w     (run_w),
    .gate_w    (gate_w),
    .work_w    (work_w)
);

// File: tb/sim_nandnet_tt_eval.sv
module sim_nandnet_tt_eval;
    localparam int NG    = 4;
    localparam int ROW_W = 5 + NG;
    localparam int MAT_W = NG * ROW_W;
    localparam int LAT   = 8 * NG;

    // column selectors
    localparam logic [ROW_W-1:0] CA  = 9'h001;
    localparam logic [ROW_W-1:0] CB  = 9'h002;
    localparam logic [ROW_W-1:0] CC  = 9'h004;
    localparam logic [ROW_W-1:0] CNA = 9'h008;
    localparam logic [ROW_W-1:0] CNB = 9'h010;
    localparam logic [ROW_W-1:0] CG0 = 9'h040;
    localparam logic [ROW_W-1:0] CG1 = 9'h080;
    localparam logic [ROW_W-1:0] CG2 = 9'h100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [MAT_W-1:0] in_matrix = '0;
    logic             out_valid;
    logic [7:0]       out_table;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // reference model state
    bit       m_busy = 1'b0;
    int       m_cnt = 0;
    bit       exp_valid = 1'b0;
    bit [7:0] exp_table = 8'h00;
    bit [7:0] m_pending = 8'h00;

    always #5 clk = ~clk;

    nandnet_tt_eval #(.NG(NG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_matrix (in_matrix),
        .out_valid (out_valid),
        .out_table (out_table)
    );

    function automatic bit [7:0] ref_table(input logic [MAT_W-1:0] m);
        bit [7:0] t = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit col [0:ROW_W];
            int top = -1;
            col[0] = i[2]; col[1] = i[1]; col[2] = i[0];
            col[3] = !i[2]; col[4] = !i[1]; col[5] = !i[0];
            for (int g = 0; g < NG; g++) begin
                bit all_one = 1'b1;
                bit any_sel = 1'b0;
                for (int j = 0; j < 6 + g; j++) begin
                    if (m[g*ROW_W + j]) begin
                        any_sel = 1'b1;
                        if (!col[j]) all_one = 1'b0;
                    end
                end
                if (m[g*ROW_W +: ROW_W] != '0) top = g;
                col[6 + g] = !all_one;
                if (!any_sel) col[6 + g] = 1'b0;
            end
            if (top >= 0) t[i] = col[6 + top];
        end
        return t;
    endfunction

    function automatic logic [MAT_W-1:0] mk(input logic [ROW_W-1:0] r0, input logic [ROW_W-1:0] r1,
                                            input logic [ROW_W-1:0] r2, input logic [ROW_W-1:0] r3);
        return {r3, r2, r1, r0};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_cnt = 0; exp_valid = 1'b0; exp_table = 8'h00;
        end else begin
            exp_valid = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    exp_valid = 1'b1;
                    exp_table = m_pending;
                    m_busy = 1'b0;
                end
            end else if (in_valid) begin
                m_busy = 1'b1;
                m_cnt = LAT;
                m_pending = ref_table(in_matrix);
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (out_valid !== exp_valid) begin
                mismatched++;
                $display("FAIL R5 out_valid actual=%0b expected=%0b (%s)", out_valid, exp_valid, tag);
            end
            compared++;
            if (out_table !== exp_table) begin
                mismatched++;
                if (exp_valid)
                    $display("FAIL %s out_table actual=%02h expected=%02h", tag, out_table, exp_table);
                else
                    $display("FAIL R7 out_table actual=%02h expected=%02h", out_table, exp_table);
            end
        end
    end

    task automatic run_one(input logic [MAT_W-1:0] m, input string t);
        @(negedge clk);
        tag = t;
        in_matrix = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || out_table !== 8'h00) begin
            mismatched++;
            $display("FAIL R1 reset actual=%0b/%02h expected=0/00", out_valid, out_table);
        end
        rst_n = 1'b1;
        run_one(mk(CA | CB | CC, '0, '0, '0), "R2");           // 7F
        run_one(mk(CA, '0, '0, '0), "R2");                     // 0F
        run_one(mk(CA | CNA, '0, '0, '0), "R2");               // FF
        run_one(mk(CA | CB, CG0, '0, '0), "R3");               // C0
        run_one(mk(CA | CG0 | CG1 | CG2, '0, '0, '0), "R3");   // forward refs ignored: 0F
        run_one(mk(CB, '0, '0, CG0 | CC), "R4");               // DD, gap rows
        run_one(mk('0, '0, '0, '0), "R4");                     // 00
        run_one(mk(CA, '0, CG1, '0), "R4");                    // unused column reads 0: FF
        run_one(mk(CA | CB, CA | CG0, CB | CG0, CG1 | CG2), "R3"); // xor: 3C
        // R6: strobe with another matrix while running
        @(negedge clk);
        tag = "R6";
        in_matrix = mk(CA | CB, CG0, '0, '0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        in_matrix = mk(CNB, '0, '0, '0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        for (int k = 0; k < 24; k++) begin
            logic [MAT_W-1:0] rm;
            rm = MAT_W'({$urandom, $urandom});
            run_one(rm, "R2");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule